// File: doc/BRIEF.md
# Vector Mask Register Unit

The unit holds a mask register of `SS` bits and carries out one operation on it per request. A request supplies an operation code, an active length `vct` and an operand word. Only mask bits whose index is below `vct` take part. Bit index 0 is the most significant bit of the mask and operand words, so index `i` sits at vector position `SS-1-i`.

Query operations read the mask and leave it as it is. They test it, count its set bits, or count the zeros that come before its first set bit. Each reports a 32-bit result and a 2-bit condition code that says whether the active bits are all zero, all one or mixed. Write operations can complement the mask, load it, load it inverted, or combine it with the operand by AND, OR or XOR. Every write of this kind clears all bits at or beyond the active length.

A separate full-restore operation writes every bit of the operand with no masking. The full mask image is always visible on an output port, which serves as the save path. Every request is answered one clock later by a single-cycle `done` strobe.

Top module: `vmr_unit`

## Requirements
- R1: After a synchronous active-low reset, `mask_img` is all zero, `done` is 0, `result` is 0 and `cc` is 0.
- R2: Operation codes are 0 test, 1 complement, 2 leading-zero count, 3 ones count, 4 load, 5 load-complement, 6 AND, 7 OR, 8 XOR and 9 full restore. `done` is 1 in exactly the cycle after a cycle with `op_valid` high, and 0 otherwise.
- R3: After any of codes 1 and 4 to 8, every mask bit with index `vct` or higher is 0. Index `i` is bit `SS-1-i` of `mask_img`.
- R4: Complement inverts each active mask bit.
- R5: Load copies the active operand bits into the mask. Load-complement copies their inverse.
- R6: AND, OR and XOR combine each active mask bit with the operand bit of the same index.
- R7: Test leaves the mask unchanged. It gives `cc` 0 when `vct` is 0 or all active bits are 0, `cc` 3 when all active bits are 1, and `cc` 1 when they are mixed. Its `result` is 0.
- R8: Ones count returns the number of set active bits and leaves the mask unchanged. Its `cc` follows the rule of R7, and both are 0 when `vct` is 0.
- R9: Leading-zero count returns the number of zero bits before the first set bit, scanning from index 0. It returns `vct` if no active bit is set. Its `cc` follows the rule of R7.
- R10: Full restore writes every bit of `operand` into the mask, regardless of `vct`. `mask_img` always shows all `SS` mask bits.
- R11: Write operations (codes 1, 4 to 9) report `result` 0 and `cc` 0. Codes 10 to 15 leave the mask unchanged and report `result` 0 and `cc` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| op_valid | input | 1 | Request strobe |
| op_code | input | 4 | Operation code (R2) |
| vct | input | VW | Active length, 0 to SS |
| operand | input | SS | Operand word, index 0 in the MSB |
| done | output | 1 | One-cycle completion strobe |
| result | output | 32 | Count result of a query |
| cc | output | 2 | Condition code |
| mask_img | output | SS | Full mask register image |

## Verification
Two situations are the hardest to reach from the ports. The first is the leading-zero count at its limits: a single set bit at the last active index, and no set bit at all, where the answer must equal `vct`. The second is a write with `vct` 0, which must wipe the whole register. The stimulus uses full restore to plant exact bit patterns beyond the active length. It then issues queries and masked writes at `vct` values of 0, 1 and `SS`, followed by a long random mix in which each operation is checked against a bench model of the mask.

// File: rtl/vmr_pkg.sv
// Package: operation codes and classification helpers for the mask unit.
// Assumes a 4-bit operation field; codes above OP_RSTR are unused.
package vmr_pkg;

    typedef enum logic [3:0] {
        OP_TEST = 4'd0,
        OP_CPL  = 4'd1,
        OP_CLZ  = 4'd2,
        OP_POPC = 4'd3,
        OP_LD   = 4'd4,
        OP_LDC  = 4'd5,
        OP_AND  = 4'd6,
        OP_OR   = 4'd7,
        OP_XOR  = 4'd8,
        OP_RSTR = 4'd9
    } vmr_op_e;

    // True for writes that clear bits beyond the active length
    function automatic logic is_masked_write(input logic [3:0] op);
        return (op == OP_CPL) || (op == OP_LD) || (op == OP_LDC) ||
               (op == OP_AND) || (op == OP_OR) || (op == OP_XOR);
    endfunction

    // True for operations that only read the mask
    function automatic logic is_query(input logic [3:0] op);
        return (op == OP_TEST) || (op == OP_CLZ) || (op == OP_POPC);
    endfunction

endpackage

// File: rtl/vmr_active_mask.sv
// Active-bit mask generator: sets the bit of every index below vct.
// Index i maps to vector position SS-1-i. vct above SS marks all bits active.
module vmr_active_mask #(
    parameter int SS = 16,
    parameter int VW = $clog2(SS + 1)
) (
    input  logic [VW-1:0] vct,
    output logic [SS-1:0] amask
);
    for (genvar i = 0; i < SS; i++) begin : g_bit
        localparam logic [VW-1:0] IDX = VW'(i);
        // One comparator per index position
        assign amask[SS-1-i] = (vct > IDX);
    end
endmodule

// File: rtl/vmr_scan.sv
// Mask scanner: counts the set active bits, finds the leading-zero run and
// forms the all-zero / all-one / mixed condition code. Purely combinational.
// Assumes amask was built from the same vct.
module vmr_scan #(
    parameter int SS = 16,
    parameter int VW = $clog2(SS + 1)
) (
    input  logic [SS-1:0] mask,
    input  logic [SS-1:0] amask,
    input  logic [VW-1:0] vct,
    output logic [VW-1:0] ones_cnt,
    output logic [VW-1:0] lz_cnt,
    output logic [1:0]    cc
);
    logic [SS-1:0] act;
    logic          none_set;
    logic          all_set;

    assign act      = mask & amask;
    assign none_set = (act == '0);
    assign all_set  = (act == amask);

    // Population count of the active bits
    always_comb begin
        ones_cnt = '0;
        for (int i = 0; i < SS; i++) begin
            ones_cnt = ones_cnt + VW'(act[i]);
        end
    end

    // Leading-zero scan from index 0; defaults to vct when nothing is set
    always_comb begin
        logic found;
        found  = 1'b0;
        lz_cnt = vct;
        for (int i = 0; i < SS; i++) begin
            if (!found && act[SS-1-i]) begin
                found  = 1'b1;
                lz_cnt = VW'(i);
            end
        end
    end

    // Condition code: 0 all-zero or empty, 3 all-one, 1 mixed
    always_comb begin
        if (vct == '0 || none_set) begin
            cc = 2'd0;
        end else if (all_set) begin
            cc = 2'd3;
        end else begin
            cc = 2'd1;
        end
    end
endmodule

// File: rtl/vmr_write_path.sv
// Write path: forms the next mask value for write operations and asserts
// wr_en for them. Masked writes clear every inactive bit; full restore
// takes the operand unchanged. Other codes leave wr_en low.
module vmr_write_path
    import vmr_pkg::*;
#(
    parameter int SS = 16
) (
    input  logic [3:0]    op,
    input  logic [SS-1:0] mask,
    input  logic [SS-1:0] operand,
    input  logic [SS-1:0] amask,
    output logic [SS-1:0] nxt,
    output logic          wr_en
);
    logic [SS-1:0] raw;

    // Select the unmasked combination for each write code
    always_comb begin
        raw   = mask;
        wr_en = 1'b1;
        case (op)
            OP_CPL:  raw = ~mask;
            OP_LD:   raw = operand;
            OP_LDC:  raw = ~operand;
            OP_AND:  raw = mask & operand;
            OP_OR:   raw = mask | operand;
            OP_XOR:  raw = mask ^ operand;
            OP_RSTR: raw = operand;
            default: wr_en = 1'b0;
        endcase
    end

    // Apply the active-length mask except for full restore
    assign nxt = (op == OP_RSTR) ? raw : (raw & amask);
endmodule

// File: rtl/vmr_unit.sv
// Vector mask register unit top. Holds the mask register and registers
// one operation per op_valid: the mask update, result and cc all appear one
// cycle later with a one-cycle done strobe. Assumes vct lies in 0..SS.
module vmr_unit
    import vmr_pkg::*;
#(
    parameter int SS = 16,
    parameter int VW = $clog2(SS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_valid,
    input  logic [3:0]    op_code,
    input  logic [VW-1:0] vct,
    input  logic [SS-1:0] operand,
    output logic          done,
    output logic [31:0]   result,
    output logic [1:0]    cc,
    output logic [SS-1:0] mask_img
);
    localparam int PADW = 32 - VW;

    logic [SS-1:0] mask_q;
    logic [SS-1:0] amask;
    logic [SS-1:0] nxt_mask;
    logic          wr_en;
    logic [VW-1:0] ones_cnt;
    logic [VW-1:0] lz_cnt;
    logic [1:0]    scan_cc;
    logic [31:0]   res_d;
    logic [1:0]    cc_d;
    logic [31:0]   res_q;
    logic [1:0]    cc_q;
    logic          done_q;

    vmr_active_mask #(.SS(SS), .VW(VW)) amask_i (
        .vct   (vct),
        .amask (amask)
    );

    vmr_scan #(.SS(SS), .VW(VW)) scan_i (
        .mask     (mask_q),
        .amask    (amask),
        .vct      (vct),
        .ones_cnt (ones_cnt),
        .lz_cnt   (lz_cnt),
        .cc       (scan_cc)
    );

    vmr_write_path #(.SS(SS)) wpath_i (
        .op      (op_code),
        .mask    (mask_q),
        .operand (operand),
        .amask   (amask),
        .nxt     (nxt_mask),
        .wr_en   (wr_en)
    );

    // Select the query result and condition code to report
    always_comb begin
        res_d = '0;
        cc_d  = 2'd0;
        case (op_code)
            OP_TEST: cc_d = scan_cc;
            OP_CLZ:  begin res_d = {{PADW{1'b0}}, lz_cnt};   cc_d = scan_cc; end
            OP_POPC: begin res_d = {{PADW{1'b0}}, ones_cnt}; cc_d = scan_cc; end
            default: ;
        endcase
    end

    // Mask register update on accepted write operations
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (op_valid && wr_en) begin
            mask_q <= nxt_mask;
        end
    end

    // Result, condition code and done strobe registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q  <= '0;
            cc_q   <= 2'd0;
            done_q <= 1'b0;
        end else begin
            done_q <= op_valid;
            if (op_valid) begin
                res_q <= res_d;
                cc_q  <= cc_d;
            end
        end
    end

    assign done     = done_q;
    assign result   = res_q;
    assign cc       = cc_q;
    assign mask_img = mask_q;
endmodule

// File: rtl/vmr_unit_chk.sv
// Property checker for vmr_unit, attached with bind. Observes ports only.
module vmr_unit_chk
    import vmr_pkg::*;
#(
    parameter int SS = 16,
    parameter int VW = $clog2(SS + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          op_valid,
    input logic [3:0]    op_code,
    input logic [VW-1:0] vct,
    input logic [SS-1:0] operand,
    input logic          done,
    input logic [31:0]   result,
    input logic [1:0]    cc,
    input logic [SS-1:0] mask_img
);
    // Active-bit set for a given length, index 0 at the MSB
    function automatic logic [SS-1:0] act_of(input logic [VW-1:0] v);
        logic [SS-1:0] a;
        a = '0;
        for (int i = 0; i < SS; i++) begin
            if (VW'(i) < v) a[SS-1-i] = 1'b1;
        end
        return a;
    endfunction

    // R2
    done_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> done);

    // R2
    no_spurious_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> !done);

    // R3
    tail_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && is_masked_write(op_code)) |=>
            ((mask_img & ~act_of($past(vct))) == '0));

    // R7
    query_keeps_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && is_query(op_code)) |=> $stable(mask_img));

    // R10
    restore_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_RSTR) |=> (mask_img == $past(operand)));

    // R8
    ones_bounded_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_POPC) |=> (result <= 32'($past(vct))));

    // R7
    empty_len_cc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && is_query(op_code) && vct == '0) |=> (cc == 2'd0));

    // R11
    unused_code_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code > OP_RSTR) |=>
            ($stable(mask_img) && result == '0 && cc == 2'd0));
endmodule

bind vmr_unit vmr_unit_chk #(.SS(SS), .VW(VW)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_valid (op_valid),
    .op_code  (op_code),
    .vct      (vct),
    .operand  (operand),
    .done     (done),
    .result   (result),
    .cc       (cc),
    .mask_img (mask_img)
);

// File: tb/vmr_unit_tb_top.sv
// Scoreboard bench: the driver computes expected items from its own mask
// model and queues them; the monitor pops one per done strobe and compares.
module vmr_unit_tb_top;
    localparam int SS = 16;
    localparam int VW = $clog2(SS + 1);

    typedef struct {
        logic [31:0]   res;
        logic [1:0]    cc;
        logic [SS-1:0] mask;
        logic [VW-1:0] vct;
        logic          mwrite;
        string         tag;
    } item_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          op_valid = 1'b0;
    logic [3:0]    op_code = '0;
    logic [VW-1:0] vct = '0;
    logic [SS-1:0] operand = '0;
    logic          done;
    logic [31:0]   result;
    logic [1:0]    cc;
    logic [SS-1:0] mask_img;

    item_t         exp_q[$];
    logic [SS-1:0] mdl = '0;
    int            n_cmp = 0;
    int            n_bad = 0;

    always #5 clk = ~clk;

    vmr_unit #(.SS(SS), .VW(VW)) dut_i (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .vct(vct), .operand(operand), .done(done), .result(result),
        .cc(cc), .mask_img(mask_img)
    );

    function automatic logic [SS-1:0] act_of(input int v);
        logic [SS-1:0] a;
        a = '0;
        for (int i = 0; i < SS; i++) if (i < v) a[SS-1-i] = 1'b1;
        return a;
    endfunction

    function automatic logic [1:0] cc_of(input logic [SS-1:0] m, input int v);
        int k;
        k = 0;
        for (int i = 0; i < v; i++) if (m[SS-1-i]) k++;
        if (v == 0 || k == 0) return 2'd0;
        if (k == v) return 2'd3;
        return 2'd1;
    endfunction

    task automatic check(input string tag, input logic ok, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Driver: apply one request and queue its expected outcome
    task automatic do_op(input logic [3:0] op, input int v, input logic [SS-1:0] opd);
        item_t it;
        logic [SS-1:0] a;
        int k;
        a = act_of(v);
        it.res = '0; it.cc = 2'd0; it.vct = VW'(v); it.mwrite = 1'b0;
        it.mask = mdl;
        case (op)
            4'd0: begin it.cc = cc_of(mdl, v); it.tag = "R7"; end
            4'd1: begin it.mask = ~mdl & a; it.mwrite = 1; it.tag = "R4"; end
            4'd2: begin
                k = v;
                for (int i = v - 1; i >= 0; i--) if (mdl[SS-1-i]) k = i;
                it.res = 32'(k); it.cc = cc_of(mdl, v); it.tag = "R9";
            end
            4'd3: begin
                k = 0;
                for (int i = 0; i < v; i++) if (mdl[SS-1-i]) k++;
                it.res = 32'(k); it.cc = cc_of(mdl, v); it.tag = "R8";
            end
            4'd4: begin it.mask = opd & a;  it.mwrite = 1; it.tag = "R5"; end
            4'd5: begin it.mask = ~opd & a; it.mwrite = 1; it.tag = "R5"; end
            4'd6: begin it.mask = mdl & opd & a;   it.mwrite = 1; it.tag = "R6"; end
            4'd7: begin it.mask = (mdl | opd) & a; it.mwrite = 1; it.tag = "R6"; end
            4'd8: begin it.mask = (mdl ^ opd) & a; it.mwrite = 1; it.tag = "R6"; end
            4'd9: begin it.mask = opd; it.tag = "R10"; end
            default: it.tag = "R11";
        endcase
        mdl = it.mask;
        @(negedge clk);
        op_valid = 1'b1; op_code = op; vct = VW'(v); operand = opd;
        exp_q.push_back(it);
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    // Idle cycle: done must stay low one cycle after an idle request slot
    task automatic idle_check();
        @(negedge clk);
        check("R2", done == 1'b0, "idle done", 64'(done), 64'd0);
    endtask

    // Monitor: compare every completion with the head of the queue
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (exp_q.size() == 0) begin
                check("R2", 1'b0, "done without request", 64'd1, 64'd0);
            end else begin
                item_t it;
                it = exp_q.pop_front();
                check(it.tag, result == it.res, "result", 64'(result), 64'(it.res));
                check(it.tag, cc == it.cc, "cc", 64'(cc), 64'(it.cc));
                check(it.tag, mask_img == it.mask, "mask", 64'(mask_img), 64'(it.mask));
                if (it.mwrite)
                    check("R3", (mask_img & ~act_of(int'(it.vct))) == '0,
                          "tail bits", 64'(mask_img), 64'(mask_img & act_of(int'(it.vct))));
            end
        end
    end

    // Watchdog: a hung run is one failed check and still prints the summary
    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Stimulus: reset, directed corners, then a random mix
    initial begin
        repeat (3) @(negedge clk);
        check("R1", mask_img == '0, "reset mask", 64'(mask_img), 64'd0);
        check("R1", done == 1'b0 && result == '0 && cc == 2'd0, "reset outputs",
              64'({done, cc, result}), 64'd0);
        rst_n = 1'b1;
        idle_check();
        do_op(4'd9, 3, 16'hFFFF);   // R10: full restore ignores vct
        do_op(4'd0, SS, '0);        // R7: all ones -> cc 3
        do_op(4'd0, 0, '0);         // R7: empty length -> cc 0
        do_op(4'd3, 0, '0);         // R8: empty length -> 0
        do_op(4'd3, SS, '0);        // R8: count SS
        do_op(4'd9, 0, 16'h0001);
        do_op(4'd2, SS, '0);        // R9: set bit at last index -> 15
        do_op(4'd2, SS - 1, '0);    // R9: none active set -> vct
        do_op(4'd0, SS - 1, '0);    // R7: all zero over active
        do_op(4'd9, 0, 16'h8000);
        do_op(4'd2, 1, '0);         // R9: first bit set -> 0, cc 3
        do_op(4'd1, 0, '0);         // R3/R4: vct 0 clears everything
        do_op(4'd1, SS, '0);        // R4: full complement
        do_op(4'd5, 1, 16'h0000);   // R5: load complement, one bit
        do_op(4'd4, 7, 16'hA5A5);   // R5
        do_op(4'd8, SS, 16'hFFFF);  // R6
        do_op(4'd6, 9, 16'hF0F0);   // R6
        do_op(4'd7, 12, 16'h0F0F);  // R6
        do_op(4'd12, 5, 16'h1234);  // R11: unused code
        do_op(4'd15, SS, '0);       // R11
        idle_check();
        for (int n = 0; n < 1500; n++) begin
            int v;
            logic [3:0] op;
            v  = $urandom_range(0, SS);
            op = ($urandom_range(0, 19) == 0) ? 4'($urandom_range(10, 15))
                                              : 4'($urandom_range(0, 9));
            do_op(op, v, SS'($urandom));
            if ($urandom_range(0, 15) == 0) idle_check();
        end
        repeat (3) @(negedge clk);
        check("R2", exp_q.size() == 0, "pending items", 64'(exp_q.size()), 64'd0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule